// File: doc/BRIEF.md
# Flag-Tagged Register File

This block is a general-purpose register file in which every entry carries its own pair of condition bits next to its value. Each entry holds a data word plus an overflow bit and a carry bit. Whenever an instruction writes a result, it writes these two bits into the same entry as the value, so there is no single global status register. Sign and zero are not stored. A read port works them out from the value it returns, so a consumer gets all four condition bits for any source register without a separate compare.

The write port has a qualifier that marks a write as a memory load. A load always leaves both condition bits of its destination cleared, whatever the overflow and carry inputs carry. For context save and restore, all condition-bit pairs are available together as one wide control word. Writing a control word replaces every pair in a single cycle and leaves the data words untouched. Register 0 is hard-wired to zero.

Top module: `flagrf`

## Requirements
- R1: While `rst` is high at a rising edge, every data word and every condition bit is cleared. After reset, any read returns data 0 with flags 4'b0100, and `ctl_rd_word` is 0.
- R2: When `wr_en` is high at a rising edge and `wr_addr` is not 0, the entry at `wr_addr` takes `wr_data`, with V = `wr_v` and C = `wr_c`. Both read ports return the new value from the next cycle on.
- R3: The read flags are encoded as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. N equals bit 31 of the returned data, and Z is 1 exactly when the returned data is zero.
- R4: A write with `wr_is_load` high stores `wr_data` and clears V and C of the destination, regardless of `wr_v` and `wr_c`.
- R5: Register 0 always reads data 0 with V = 0 and C = 0 (flags 4'b0100). Writes to it change nothing, and `ctl_rd_word[1:0]` is always 0.
- R6: When a read address equals a nonzero `wr_addr` while `wr_en` is high, the read port returns `wr_data` and the flags of that pending write in the same cycle. Load gating applies to these flags too.
- R7: `ctl_rd_word` shows the stored pairs, with register i's C in bit 2i and its V in bit 2i+1. It does not bypass writes in the same cycle.
- R8: When `ctl_wr_en` is high at a rising edge, each register i from 1 to 31 takes V = `ctl_wr_word[2i+1]` and C = `ctl_wr_word[2i]`. No data word changes. Read ports do not bypass the control write.
- R9: If a normal write and a control write fall in the same cycle, the destination register of the normal write takes its flags from the normal write. All other registers take theirs from the control word.
- R10: With `wr_en` and `ctl_wr_en` both low, no stored value or flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr_a | input | 5 | Read port A register index |
| rd_data_a | output | 32 | Read port A data |
| rd_flags_a | output | 4 | Read port A flags {N,Z,V,C} |
| rd_addr_b | input | 5 | Read port B register index |
| rd_data_b | output | 32 | Read port B data |
| rd_flags_b | output | 4 | Read port B flags {N,Z,V,C} |
| wr_en | input | 1 | Result write enable |
| wr_addr | input | 5 | Destination register index |
| wr_data | input | 32 | Result value |
| wr_v | input | 1 | Overflow bit of the result |
| wr_c | input | 1 | Carry bit of the result |
| wr_is_load | input | 1 | Marks the write as a memory load (clears V and C) |
| ctl_wr_en | input | 1 | Restore all flag pairs from `ctl_wr_word` |
| ctl_wr_word | input | 64 | Packed flag pairs to restore |
| ctl_rd_word | output | 64 | Packed flag pairs currently stored |

## Verification
A result write and a control-word restore can land in the same cycle, and both target the flag pairs. The bench makes this happen in a directed case that writes a restore word whose pair for the destination differs from the result flags. It also turns on both enables together at random during the long random run. The result is judged through `ctl_rd_word` and through the reads in the following cycle, against a bench model that applies the control word first and the normal write on top of it.

// File: rtl/flagrf_pkg.sv
package flagrf_pkg;

  // Flag bundle returned by a read port; bit order {n,z,v,c}
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } rd_flags_t;

  // Pair as written: a load forces both bits low
  function automatic logic [1:0] gate_pair(input logic is_load, input logic v, input logic c);
    return is_load ? 2'b00 : {v, c};
  endfunction

  // Build the four read flags from the sign bit, a zero test and the stored pair
  function automatic rd_flags_t derive_flags(input logic msb, input logic is_zero,
                                             input logic [1:0] pair);
    rd_flags_t f;
    f.n = msb;
    f.z = is_zero;
    f.v = pair[1];
    f.c = pair[0];
    return f;
  endfunction

endpackage

// File: rtl/frf_bank.sv
module frf_bank #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [1:0]        wr_pair,
  input  logic              ctl_wr_en,
  input  logic [2*NREG-1:0] ctl_wr_word,
  output logic [DW-1:0]     data_q [NREG],
  output logic [1:0]        pair_q [NREG]
);

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    if (g == 0) begin : g_zero
      assign data_q[g] = '0;
      assign pair_q[g] = 2'b00;
    end else begin : g_live
      logic hit;
      logic [DW-1:0] d_r;
      logic [1:0]    p_r;
      assign hit = wr_en && (wr_addr == AW'(g));
      always_ff @(posedge clk) begin
        if (rst) begin
          d_r <= '0;
          p_r <= 2'b00;
        end else begin
          if (hit) d_r <= wr_data;
          if (hit)            p_r <= wr_pair;
          else if (ctl_wr_en) p_r <= ctl_wr_word[2*g +: 2];
        end
      end
      assign data_q[g] = d_r;
      assign pair_q[g] = p_r;
    end
  end

endmodule

// File: rtl/frf_rdport.sv
module frf_rdport
  import flagrf_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] data_q [NREG],
  input  logic [1:0]    pair_q [NREG],
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    wr_pair,
  output logic [DW-1:0] rd_data,
  output logic [3:0]    rd_flags
);

  logic          bypass;
  logic [DW-1:0] sel_data;
  logic [1:0]    sel_pair;
  rd_flags_t     fl;

  assign bypass = wr_en && (wr_addr == rd_addr) && (rd_addr != '0);

  always_comb begin
    sel_data = '0;
    sel_pair = 2'b00;
    if (bypass) begin
      sel_data = wr_data;
      sel_pair = wr_pair;
    end else if (int'(rd_addr) < NREG) begin
      sel_data = data_q[rd_addr];
      sel_pair = pair_q[rd_addr];
    end
  end

  assign fl       = derive_flags(sel_data[DW-1], sel_data == '0, sel_pair);
  assign rd_data  = sel_data;
  assign rd_flags = fl;

endmodule

// File: rtl/frf_ctlpack.sv
module frf_ctlpack #(
  parameter int NREG = 32
) (
  input  logic [1:0]        pair_q [NREG],
  output logic [2*NREG-1:0] ctl_rd_word
);

  for (genvar g = 0; g < NREG; g++) begin : g_pk
    assign ctl_rd_word[2*g +: 2] = pair_q[g];
  end

endmodule

// File: rtl/flagrf.sv
module flagrf
  import flagrf_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int AW   = $clog2(NREG),
  parameter int CW   = 2 * NREG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr_a,
  output logic [DW-1:0] rd_data_a,
  output logic [3:0]    rd_flags_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_b,
  output logic [3:0]    rd_flags_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_v,
  input  logic          wr_c,
  input  logic          wr_is_load,
  input  logic          ctl_wr_en,
  input  logic [CW-1:0] ctl_wr_word,
  output logic [CW-1:0] ctl_rd_word
);

  localparam int NPORT = 2;

  logic [DW-1:0] data_q [NREG];
  logic [1:0]    pair_q [NREG];
  logic [1:0]    wr_pair;
  logic [AW-1:0] rd_addr_v [NPORT];
  logic [DW-1:0] rd_data_v [NPORT];
  logic [3:0]    rd_flags_v[NPORT];

  assign wr_pair = gate_pair(wr_is_load, wr_v, wr_c);

  frf_bank #(.NREG(NREG), .DW(DW), .AW(AW)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_pair(wr_pair),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_word(ctl_wr_word),
    .data_q(data_q), .pair_q(pair_q)
  );

  assign rd_addr_v[0] = rd_addr_a;
  assign rd_addr_v[1] = rd_addr_b;

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    frf_rdport #(.NREG(NREG), .DW(DW), .AW(AW)) u_rd (
      .rd_addr(rd_addr_v[p]), .data_q(data_q), .pair_q(pair_q),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_pair(wr_pair),
      .rd_data(rd_data_v[p]), .rd_flags(rd_flags_v[p])
    );
  end

  assign rd_data_a  = rd_data_v[0];
  assign rd_flags_a = rd_flags_v[0];
  assign rd_data_b  = rd_data_v[1];
  assign rd_flags_b = rd_flags_v[1];

  frf_ctlpack #(.NREG(NREG)) u_pack (
    .pair_q(pair_q), .ctl_rd_word(ctl_rd_word)
  );

endmodule

// File: rtl/flagrf_chk.sv
module flagrf_chk #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int AW   = $clog2(NREG),
  parameter int CW   = 2 * NREG
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          wr_v,
  input logic          wr_c,
  input logic          wr_is_load,
  input logic          ctl_wr_en,
  input logic [CW-1:0] ctl_wr_word,
  input logic [CW-1:0] ctl_rd_word,
  input logic [AW-1:0] rd_addr_a,
  input logic [DW-1:0] rd_data_a,
  input logic [3:0]    rd_flags_a
);

  // Named events for the properties
  logic          ev_commit;
  logic          ev_hit_a;
  logic [AW-1:0] prev_addr;
  logic [1:0]    prev_pair;

  assign ev_commit = wr_en && (wr_addr != '0);
  assign ev_hit_a  = ev_commit && (rd_addr_a == wr_addr);

  always_ff @(posedge clk) prev_addr <= wr_addr;
  assign prev_pair = ctl_rd_word[{prev_addr, 1'b0} +: 2];

  AST_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    ev_commit && !wr_is_load |=> prev_pair == $past({wr_v, wr_c}));          // R2

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ev_commit && wr_is_load |=> prev_pair == 2'b00);                         // R4

  AST_REG0_READ: assert property (@(posedge clk) disable iff (rst)
    rd_addr_a == '0 |-> rd_data_a == '0 && rd_flags_a == 4'b0100);           // R5

  AST_REG0_PAIR: assert property (@(posedge clk) disable iff (rst)
    ctl_rd_word[1:0] == 2'b00);                                              // R5

  AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (rst)
    ev_hit_a |-> rd_data_a == wr_data);                                      // R6

  AST_CTL_RESTORE: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_en && !wr_en |=> ctl_rd_word[CW-1:2] == $past(ctl_wr_word[CW-1:2])); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en && !ctl_wr_en |=> $stable(ctl_rd_word));                          // R10

endmodule

bind flagrf flagrf_chk #(.NREG(NREG), .DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_v(wr_v), .wr_c(wr_c), .wr_is_load(wr_is_load), .ctl_wr_en(ctl_wr_en),
  .ctl_wr_word(ctl_wr_word), .ctl_rd_word(ctl_rd_word), .rd_addr_a(rd_addr_a),
  .rd_data_a(rd_data_a), .rd_flags_a(rd_flags_a)
);

// File: tb/flagrf_bench.sv
module flagrf_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic [31:0] rd_data_a, rd_data_b, wr_data;
  logic [3:0]  rd_flags_a, rd_flags_b;
  logic        wr_en, wr_v, wr_c, wr_is_load, ctl_wr_en;
  logic [63:0] ctl_wr_word, ctl_rd_word;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] m_data [32];
  logic        m_v [32];
  logic        m_c [32];

  always #2 clk = ~clk;   // 250 MHz

  flagrf u_flagrf (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a), .rd_flags_a(rd_flags_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .rd_flags_b(rd_flags_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_v(wr_v), .wr_c(wr_c),
    .wr_is_load(wr_is_load), .ctl_wr_en(ctl_wr_en), .ctl_wr_word(ctl_wr_word),
    .ctl_rd_word(ctl_rd_word)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected {data, N, Z, V, C} of a read, including bypass of the pending write
  function automatic logic [35:0] exp_read(input logic [4:0] a);
    logic [31:0] d;
    logic v, c;
    if (a == 5'd0) begin
      d = '0; v = 1'b0; c = 1'b0;
    end else if (wr_en && wr_addr == a) begin
      d = wr_data; v = wr_is_load ? 1'b0 : wr_v; c = wr_is_load ? 1'b0 : wr_c;
    end else begin
      d = m_data[a]; v = m_v[a]; c = m_c[a];
    end
    return {d, d[31], (d == 32'd0), v, c};
  endfunction

  function automatic logic [63:0] exp_ctl();
    logic [63:0] w = '0;
    for (int i = 0; i < 32; i++) begin
      w[2*i]   = m_c[i];
      w[2*i+1] = m_v[i];
    end
    return w;
  endfunction

  task automatic idle_inputs();
    wr_en = 0; wr_addr = 0; wr_data = 0; wr_v = 0; wr_c = 0; wr_is_load = 0;
    ctl_wr_en = 0; ctl_wr_word = 0;
  endtask

  // Inputs are already set after a falling edge; check, clock, update model
  task automatic step(input string tag);
    #1;
    chk(tag, {28'd0, rd_data_a, rd_flags_a}, {28'd0, exp_read(rd_addr_a)});
    chk(tag, {28'd0, rd_data_b, rd_flags_b}, {28'd0, exp_read(rd_addr_b)});
    chk({tag, "/R7"}, ctl_rd_word, exp_ctl());
    @(posedge clk);
    if (ctl_wr_en)
      for (int i = 1; i < 32; i++) begin
        m_v[i] = ctl_wr_word[2*i+1];
        m_c[i] = ctl_wr_word[2*i];
      end
    if (wr_en && wr_addr != 5'd0) begin
      m_data[wr_addr] = wr_data;
      m_v[wr_addr] = wr_is_load ? 1'b0 : wr_v;
      m_c[wr_addr] = wr_is_load ? 1'b0 : wr_c;
    end
    @(negedge clk);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [31:0] d,
                          input logic v, input logic c, input logic ld, input string tag);
    idle_inputs();
    wr_en = 1; wr_addr = a; wr_data = d; wr_v = v; wr_c = c; wr_is_load = ld;
    step(tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) begin m_data[i] = 0; m_v[i] = 0; m_c[i] = 0; end
    idle_inputs();
    rd_addr_a = 5'd7; rd_addr_b = 5'd19;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    step("R1");

    // R2 / R3: plain writes, negative value, zero value with flags
    do_write(5'd7, 32'h8000_0001, 1, 0, 0, "R2");
    rd_addr_a = 5'd7; rd_addr_b = 5'd7; idle_inputs(); step("R3");
    do_write(5'd19, 32'd0, 0, 1, 0, "R2");
    rd_addr_a = 5'd19; idle_inputs(); step("R3");

    // R4: load ignores V/C inputs
    do_write(5'd7, 32'h1234_5678, 1, 1, 1, "R4");
    rd_addr_a = 5'd7; idle_inputs(); step("R4");

    // R5: register 0 write ignored
    rd_addr_a = 5'd0; rd_addr_b = 5'd0;
    do_write(5'd0, 32'hFFFF_FFFF, 1, 1, 0, "R5");
    idle_inputs(); step("R5");

    // R6: same-cycle bypass on both ports, including load gating
    rd_addr_a = 5'd12; rd_addr_b = 5'd12;
    do_write(5'd12, 32'hCAFE_0000, 1, 1, 0, "R6");
    do_write(5'd12, 32'h0000_0000, 1, 1, 1, "R6");

    // R8: control restore changes flags only
    idle_inputs();
    ctl_wr_en = 1; ctl_wr_word = 64'hA5A5_5A5A_F0F0_0F0F;
    rd_addr_a = 5'd7; rd_addr_b = 5'd3;
    step("R8");
    idle_inputs(); step("R8");

    // R9: collision, normal write wins for its register
    idle_inputs();
    ctl_wr_en = 1; ctl_wr_word = 64'hFFFF_FFFF_FFFF_FFFF;
    wr_en = 1; wr_addr = 5'd5; wr_data = 32'h55; wr_v = 0; wr_c = 0;
    rd_addr_a = 5'd6; rd_addr_b = 5'd9;
    step("R9");
    rd_addr_a = 5'd5; rd_addr_b = 5'd4; idle_inputs(); step("R9");

    // R10: disabled write with live data changes nothing
    idle_inputs();
    wr_addr = 5'd5; wr_data = 32'hDEAD_BEEF; wr_v = 1; wr_c = 1;
    rd_addr_a = 5'd5;
    step("R10");
    idle_inputs(); step("R10");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      idle_inputs();
      wr_en       = ($urandom_range(0, 9) < 7);
      wr_addr     = 5'($urandom);
      wr_data     = ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom;
      wr_v        = 1'($urandom);
      wr_c        = 1'($urandom);
      wr_is_load  = ($urandom_range(0, 3) == 0);
      ctl_wr_en   = ($urandom_range(0, 19) == 0);
      ctl_wr_word = {$urandom, $urandom};
      rd_addr_a   = ($urandom_range(0, 3) == 0) ? wr_addr : 5'($urandom);
      rd_addr_b   = ($urandom_range(0, 3) == 0) ? wr_addr : 5'($urandom);
      step("R2");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule